// File: doc/BRIEF.md
# Dual-Mode Monitor Identification Channel

This block is the display end of a monitor identification link that works in two modes. After reset it is in streaming mode: with no clock from the host, it sends a 128-byte identification table bit by bit. The bit clock is a vertical-sync-derived input (`vclk_in`), and the block advances one bit on each rising edge of that input. Bytes are sent most significant bit first. Each byte carries eight data bits and then one released filler bit.

A falling edge on the two-wire clock line (`scl_in`) tells the block that a host wants addressed two-wire access. The stream stops and the block waits for a START condition followed by its device address. When the address matches, the block acknowledges it by pulling the data line low, then raises a single-cycle hit pulse. If no matching address arrives within 128 VCLK cycles, the block returns to streaming from the first byte.

All three line inputs pass through two-stage synchronisers into the system clock domain. Every edge and bus condition is detected on the synchronised copies.

Top module: `dual_mode_id_channel`

## Requirements
- R1: After reset the block is in streaming mode (`addr_mode`=0) with `addr_hit`=0, `sda_out`=0, and it presents bit 7 of byte 0.
- R2: In streaming mode each byte goes out MSB first as 8 data bits then one released filler bit. Each rising edge of `vclk_in` moves to the next bit. Byte k of the table is (29*k + 17) mod 256.
- R3: `sda_out` is always 0. `sda_oe` is 1 in only two cases: a 0 data bit in streaming mode, or the acknowledge slot. A 1 is sent by releasing the line.
- R4: After byte 127 the stream wraps to byte 0.
- R5: A falling edge on `scl_in` in streaming mode sets `addr_mode`=1 and stops the stream (`sda_oe`=0), whatever `vclk_in` does afterwards.
- R6: In addressed mode, VCLK rising edges counted from entry (counter cleared on entry) return the block to streaming on the 128th edge, restarting at byte 0 bit 7. After 127 edges the block is still in addressed mode.
- R7: After a START (SDA falling while SCL is high), the first 7 bits clocked on SCL rising edges form the address, MSB first; the 8th bit (read/write) is ignored. Address 7'h50 is acknowledged: `sda_oe`=1 from the SCL fall after the 8th bit until the SCL fall after the 9th.
- R8: `addr_hit` is high for exactly one system clock, right after the SCL fall that ends the acknowledge bit.
- R9: Any other address gets no acknowledge and no `addr_hit`.
- R10: After a hit, VCLK edges do not return the block to streaming until a STOP (SDA rising while SCL is high). After the STOP, counting restarts from 0 and 128 further edges revert.
- R11: If the acknowledge ends in the same cycle as the 128th VCLK edge, the hit wins: the block stays addressed, pulses `addr_hit` and clears the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vclk_in | input | 1 | Vertical-sync-derived bit clock, asynchronous |
| scl_in | input | 1 | Two-wire clock line, asynchronous |
| sda_in | input | 1 | Two-wire data line as seen on the pad |
| sda_out | output | 1 | Data pad output value (always 0) |
| sda_oe | output | 1 | Data pad output enable; high pulls the line low |
| addr_mode | output | 1 | High while in addressed two-wire mode |
| addr_hit | output | 1 | One-cycle pulse after a matching address is acknowledged |

## Verification
Two events can land in the same system cycle: the SCL fall that ends the acknowledge of a matching address, and the 128th VCLK rising edge that would end addressed mode. The bench first brings the counter to 127 edges. During the ninth SCL clock of a matching address it then changes `scl_in` and `vclk_in` on the same clock. Both inputs pass through synchronisers of equal depth, so both edges are seen in one cycle. The result passes only if `addr_mode` stays high and one hit pulse is counted. Two further checks confirm the counter was cleared rather than left at its limit: more than 128 later VCLK edges do not cause a revert, and after a STOP exactly 128 edges do.

// File: rtl/idch_pkg.sv
package idch_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_ACK,
    RX_ENGAGED
  } rx_state_t;

  // Identification table contents: entry k = 29*k + 17 (mod 256)
  function automatic logic [7:0] id_rom_byte(input logic [7:0] idx);
    logic [7:0] prod;
    prod = idx * 8'd29;
    return prod + 8'd17;
  endfunction

  // Which data bit of a byte is on the wire for a given slot (MSB first)
  function automatic logic [2:0] slot_to_bit(input logic [3:0] slot);
    return 3'd7 - slot[2:0];
  endfunction

  function automatic logic is_filler_slot(input logic [3:0] slot);
    return slot == 4'd8;
  endfunction

endpackage

// File: rtl/idch_sync.sv
module idch_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  logic [N-1:0] meta;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[g] <= RST_VAL[g];
        lvl[g]  <= RST_VAL[g];
        prv[g]  <= RST_VAL[g];
      end else begin
        meta[g] <= d_in[g];
        lvl[g]  <= meta[g];
        prv[g]  <= lvl[g];
      end
    end
  end
endmodule

// File: rtl/idch_stream_tx.sv
module idch_stream_tx
  import idch_pkg::*;
#(
  parameter int BYTES = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       step,
  output logic       drive_low,
  output logic [3:0] bit_idx
);
  localparam int AW = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [AW-1:0] byte_idx;
  logic [7:0]    cur_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx <= '0;
      bit_idx  <= '0;
    end else if (!run) begin
      byte_idx <= '0;
      bit_idx  <= '0;
    end else if (step) begin
      if (is_filler_slot(bit_idx)) begin
        bit_idx  <= '0;
        byte_idx <= (byte_idx == AW'(BYTES - 1)) ? '0 : byte_idx + AW'(1);
      end else begin
        bit_idx <= bit_idx + 4'd1;
      end
    end
  end

  always_comb begin
    cur_byte  = id_rom_byte(8'(byte_idx));
    drive_low = run && !is_filler_slot(bit_idx) && !cur_byte[slot_to_bit(bit_idx)];
  end
endmodule

// File: rtl/idch_addr_rx.sv
module idch_addr_rx
  import idch_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic ack_drive,
  output logic hit_evt,
  output logic engaged,
  output logic addr_hit
);
  rx_state_t  state;
  logic [6:0] shreg;
  logic [3:0] nbits;
  logic       start_cond, stop_cond;

  assign start_cond = en && scl_lvl && sda_fall;
  assign stop_cond  = en && scl_lvl && sda_rise;
  assign ack_drive  = (state == RX_ACK);
  assign engaged    = (state == RX_ENGAGED);
  assign hit_evt    = en && ack_drive && scl_fall && !stop_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      shreg    <= '0;
      nbits    <= '0;
      addr_hit <= 1'b0;
    end else begin
      addr_hit <= hit_evt;
      if (!en || stop_cond) begin
        state <= RX_IDLE;
        nbits <= '0;
      end else if (start_cond && state != RX_ENGAGED) begin
        state <= RX_SHIFT;
        nbits <= '0;
      end else begin
        case (state)
          RX_SHIFT: begin
            if (scl_rise && nbits != 4'd8) begin
              if (nbits < 4'd7) shreg <= {shreg[5:0], sda_lvl};
              nbits <= nbits + 4'd1;
            end else if (scl_fall && nbits == 4'd8) begin
              state <= (shreg == DEV_ADDR) ? RX_ACK : RX_IDLE;
            end
          end
          RX_ACK:  if (scl_fall) state <= RX_ENGAGED;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idch_mode_ctrl.sv
module idch_mode_ctrl #(
  parameter int LIMIT = 128,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_fall,
  input  logic          vclk_rise,
  input  logic          hit_evt,
  input  logic          engaged,
  output logic          addr_mode,
  output logic [CW-1:0] revert_cnt
);
  logic revert_evt;

  assign revert_evt = addr_mode && vclk_rise && !engaged && !hit_evt &&
                      (revert_cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_mode  <= 1'b0;
      revert_cnt <= '0;
    end else if (!addr_mode) begin
      if (scl_fall) begin
        addr_mode  <= 1'b1;
        revert_cnt <= '0;
      end
    end else if (engaged || hit_evt) begin
      revert_cnt <= '0;
    end else if (revert_evt) begin
      addr_mode  <= 1'b0;
      revert_cnt <= '0;
    end else if (vclk_rise) begin
      revert_cnt <= revert_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/dual_mode_id_channel.sv
module dual_mode_id_channel #(
  parameter int         TABLE_BYTES = 128,
  parameter int         REVERT_LIMIT = 128,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vclk_in,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out,
  output logic sda_oe,
  output logic addr_mode,
  output logic addr_hit
);
  localparam int CW = (REVERT_LIMIT > 1) ? $clog2(REVERT_LIMIT) : 1;
  localparam int SCL_B = 0;
  localparam int SDA_B = 1;
  localparam int VCK_B = 2;

  logic [2:0]    lvl, prv;
  logic          scl_rise, scl_fall, sda_rise, sda_fall, vclk_rise;
  logic          stream_low, ack_drive, hit_evt, engaged;
  logic [3:0]    bit_idx;
  logic [CW-1:0] revert_cnt;

  idch_sync #(.N(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({vclk_in, sda_in, scl_in}),
    .lvl(lvl), .prv(prv)
  );

  assign scl_rise  =  lvl[SCL_B] && !prv[SCL_B];
  assign scl_fall  = !lvl[SCL_B] &&  prv[SCL_B];
  assign sda_rise  =  lvl[SDA_B] && !prv[SDA_B];
  assign sda_fall  = !lvl[SDA_B] &&  prv[SDA_B];
  assign vclk_rise =  lvl[VCK_B] && !prv[VCK_B];

  idch_stream_tx #(.BYTES(TABLE_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .run(!addr_mode), .step(vclk_rise),
    .drive_low(stream_low), .bit_idx(bit_idx)
  );

  idch_addr_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(addr_mode),
    .scl_lvl(lvl[SCL_B]), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(lvl[SDA_B]), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .ack_drive(ack_drive), .hit_evt(hit_evt), .engaged(engaged),
    .addr_hit(addr_hit)
  );

  idch_mode_ctrl #(.LIMIT(REVERT_LIMIT)) u_mode (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .vclk_rise(vclk_rise),
    .hit_evt(hit_evt), .engaged(engaged),
    .addr_mode(addr_mode), .revert_cnt(revert_cnt)
  );

  assign sda_out = 1'b0;
  assign sda_oe  = stream_low || ack_drive;
endmodule

// File: rtl/idch_checker.sv
module idch_checker #(
  parameter int LIMIT = 128,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_mode,
  input logic          addr_hit,
  input logic          sda_oe,
  input logic          scl_fall,
  input logic          vclk_rise,
  input logic          ack_drive,
  input logic          engaged,
  input logic [3:0]    bit_idx,
  input logic [CW-1:0] revert_cnt
);
  assert_filler_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_mode && bit_idx == 4'd8) |-> !sda_oe);

  assert_stream_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode && !ack_drive) |-> !sda_oe);

  assert_enter_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_mode && scl_fall) |=> addr_mode);

  assert_revert_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode && vclk_rise && !engaged && !ack_drive &&
     revert_cnt == CW'(LIMIT - 1)) |=> !addr_mode);

  assert_hit_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> !addr_hit);

  assert_engaged_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    engaged |=> addr_mode);
endmodule

bind dual_mode_id_channel idch_checker #(.LIMIT(REVERT_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .addr_hit(addr_hit),
  .sda_oe(sda_oe), .scl_fall(scl_fall), .vclk_rise(vclk_rise),
  .ack_drive(ack_drive), .engaged(engaged), .bit_idx(bit_idx),
  .revert_cnt(revert_cnt)
);

// File: tb/test_dual_mode_id_channel.sv
module test_dual_mode_id_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vclk_in = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic sda_out, sda_oe, addr_mode, addr_hit;
  int   compared = 0, mismatched = 0, hit_cnt = 0;

  always #5 clk = ~clk;

  dual_mode_id_channel i_dual_mode_id_channel (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .scl_in(scl_in),
    .sda_in(sda_in), .sda_out(sda_out), .sda_oe(sda_oe),
    .addr_mode(addr_mode), .addr_hit(addr_hit)
  );

  always @(negedge clk) if (addr_hit === 1'b1) hit_cnt++;

  function automatic logic [7:0] ref_byte(input int k);
    int v = 17;
    for (int i = 0; i < k; i++) v = (v + 29) % 256;
    return 8'(v);
  endfunction

  function automatic int ref_oe(input int b, input int slot);
    logic [7:0] d = ref_byte(b % 128);
    if (slot == 8) return 0;
    return d[7 - slot] ? 0 : 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vclk_in = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
    ticks(4); rst_n = 1'b1; ticks(4);
  endtask

  task automatic vclk_pulse();
    vclk_in = 1'b1; ticks(5); vclk_in = 1'b0; ticks(5);
  endtask

  task automatic enter_addr();
    scl_in = 1'b0; ticks(6); scl_in = 1'b1; ticks(6);
  endtask

  task automatic i2c_start();
    sda_in = 1'b1; scl_in = 1'b1; ticks(6); sda_in = 1'b0; ticks(6);
    scl_in = 1'b0; ticks(6);
  endtask

  task automatic i2c_stop();
    sda_in = 1'b0; ticks(6); scl_in = 1'b1; ticks(6); sda_in = 1'b1; ticks(6);
  endtask

  // Sends one address byte and the acknowledge clock; collide puts a
  // VCLK rise on the same cycle as the SCL fall that ends the ack slot.
  task automatic send_addr(input logic [7:0] b, input bit exp_ack, input bit collide);
    int h0;
    for (int i = 7; i >= 0; i--) begin
      sda_in = b[i]; ticks(6); scl_in = 1'b1; ticks(6); scl_in = 1'b0; ticks(6);
    end
    check(exp_ack ? "R7 ack slot driven" : "R9 no ack", int'(sda_oe), int'(exp_ack));
    h0 = hit_cnt;
    sda_in = 1'b1; ticks(6); scl_in = 1'b1; ticks(6);
    if (collide) vclk_in = 1'b1;
    scl_in = 1'b0; ticks(6);
    check(exp_ack ? "R8 single hit" : "R9 no hit", hit_cnt - h0, int'(exp_ack));
    check("R7 ack released", int'(sda_oe), 0);
    if (collide) begin vclk_in = 1'b0; ticks(6); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset state
    check("R1 mode", int'(addr_mode), 0);
    check("R1 hit", int'(addr_hit), 0);
    check("R1 sda_out", int'(sda_out), 0);
    check("R1 first bit", int'(sda_oe), ref_oe(0, 0));

    // R2 / R3 / R4 full table plus wrap
    for (int b = 0; b < 130; b++)
      for (int s = 0; s < 9; s++) begin
        check(b < 128 ? "R2 R3 stream bit" : "R4 wrap bit", int'(sda_oe), ref_oe(b, s));
        vclk_pulse();
      end

    // R5 entry and silence
    do_reset();
    enter_addr();
    check("R5 mode entered", int'(addr_mode), 1);
    check("R5 stream stopped", int'(sda_oe), 0);
    for (int i = 0; i < 3; i++) vclk_pulse();
    check("R5 still silent", int'(sda_oe), 0);

    // R6 revert boundary (3 edges already counted)
    for (int i = 3; i < 127; i++) vclk_pulse();
    check("R6 127 edges stay", int'(addr_mode), 1);
    vclk_pulse();
    check("R6 128th edge reverts", int'(addr_mode), 0);
    check("R6 restart byte 0", int'(sda_oe), ref_oe(0, 0));
    check("R3 sda_out low", int'(sda_out), 0);

    // R11 collision, then R10 hold and release
    do_reset();
    enter_addr();
    for (int i = 0; i < 127; i++) vclk_pulse();
    i2c_start();
    send_addr({7'h50, 1'b1}, 1'b1, 1'b1);
    check("R11 hit wins over revert", int'(addr_mode), 1);
    for (int i = 0; i < 200; i++) vclk_pulse();
    check("R10 engaged holds", int'(addr_mode), 1);
    i2c_stop();
    for (int i = 0; i < 127; i++) vclk_pulse();
    check("R10 recount 127", int'(addr_mode), 1);
    vclk_pulse();
    check("R10 recount 128 reverts", int'(addr_mode), 0);

    // R9 directed wrong address
    do_reset();
    enter_addr();
    i2c_start();
    send_addr({7'h51, 1'b0}, 1'b0, 1'b0);
    check("R9 mode kept", int'(addr_mode), 1);

    // Random addresses
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      logic       rw;
      int         np;
      do_reset();
      enter_addr();
      np = int'($urandom % 100);
      for (int i = 0; i < np; i++) vclk_pulse();
      a  = ($urandom % 2 == 0) ? 7'h50 : 7'($urandom);
      rw = 1'($urandom);
      i2c_start();
      send_addr({a, rw}, a == 7'h50, 1'b0);
      check("R7 R9 mode after address", int'(addr_mode), 1);
      i2c_stop();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule